// File: doc/BRIEF.md
# Register-Mapped Packet Mailbox

This block is a memory-mapped slave that lets software exchange packet-formatted transactions with a streaming fabric, one 64-bit beat at a time. It never interprets what the packets contain.

To transmit, software stores the low and high 32-bit halves of a beat in two data registers. It then writes a control register whose two low bits carry the packet framing. That control write captures the beat and presents it on a valid/ready stream. If software tries to commit another beat before the previous one has been taken, the control write is held off with a wait signal.

To receive, completion beats arrive on a second valid/ready stream and queue in a 16-entry FIFO. Software polls a status word that holds the number of queued beats and two read-to-clear framing flags for the beat at the head of the queue. It reads the head beat's low word, then its high word; the read of the high word removes the beat from the queue. Payload bytes pass through exactly as written or received. They may sit aligned or unaligned within the 64 bits, and the block does not move them.

The slave answers reads in the same cycle: `mm_rdata` is valid whenever `mm_read` is high and `mm_waitreq` is low.

Top module: `pkt_mailbox`

## Requirements
- R1: After reset, `tx_valid` is 0, `rx_ready` is 1, and every mapped register reads 0, including the status word.
- R2: Offsets 0x2000 (low word) and 0x2004 (high word) are read/write 32-bit data registers that hold the next transmit beat.
- R3: A write to 0x2008 that is accepted captures {0x2004, 0x2000} as `tx_data`, with `tx_sop` taken from write bit 1 and `tx_eop` from write bit 0, and raises `tx_valid`. All four combinations are legal, and 00 marks a middle beat. `tx_data`, `tx_sop` and `tx_eop` stay stable until a cycle with `tx_ready` high. A read of 0x2008 returns the last written flags in bits 1:0.
- R4: While a beat is still pending, a write to 0x2008 raises `mm_waitreq` until the beat is taken. No other access ever raises `mm_waitreq`. Writes to the data registers while a beat is pending do not change that beat.
- R5: Received beats are queued in order, up to 16. `rx_ready` is 0 exactly when 16 beats are queued, and a beat offered while full is not stored.
- R6: Status at 0x2010 returns the queued beat count in bits 15:8. Bits 31:16 and 7:2 read 0.
- R7: Status bit 1 (start flag) and bit 0 (end flag) become set one cycle after a beat reaches the head of the queue carrying the start or end marker. They stay set until a status read, which returns the value and then clears both flags.
- R8: 0x2014 returns the low 32 bits and 0x2018 the high 32 bits of the head beat. A read of 0x2018 pops the head beat. With an empty queue both read 0 and nothing changes.
- R9: Reads of any other offset return 0. Writes to any offset other than 0x2000, 0x2004 and 0x2008 change nothing.
- R10: Beat data is carried bit for bit in both directions, without realignment or byte reordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mm_addr | input | 14 | Byte address |
| mm_read | input | 1 | Read strobe |
| mm_write | input | 1 | Write strobe |
| mm_wdata | input | 32 | Write data |
| mm_rdata | output | 32 | Read data, same cycle |
| mm_waitreq | output | 1 | Access stall |
| tx_data | output | 64 | Transmit beat |
| tx_sop | output | 1 | Transmit start-of-packet |
| tx_eop | output | 1 | Transmit end-of-packet |
| tx_valid | output | 1 | Transmit beat valid |
| tx_ready | input | 1 | Transmit beat accepted |
| rx_data | input | 64 | Receive beat |
| rx_sop | input | 1 | Receive start-of-packet |
| rx_eop | input | 1 | Receive end-of-packet |
| rx_valid | input | 1 | Receive beat valid |
| rx_ready | output | 1 | Receive queue has room |

## Verification
The bench drives all four framing combinations on transmit. It holds `tx_ready` low so that it can commit a second beat into a pending one and rewrite a data register under it. A design that dropped the stall or fed the live registers to the output would show the wrong beat. The bench fills the receive queue to exactly 16 and offers one more beat. A counter off by one would either lower `rx_ready` one beat early or overwrite the oldest entry, and the drain that follows would then break the computed data order. The status word is read twice in a row at each stage, and the empty queue is popped. This exposes flags that are not cleared by a read, flags that re-arm without a new head beat, and a pop that underflows the count.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [15:0] OFF_TX_LO  = 16'h2000;
  localparam logic [15:0] OFF_TX_HI  = 16'h2004;
  localparam logic [15:0] OFF_CTRL   = 16'h2008;
  localparam logic [15:0] OFF_STATUS = 16'h2010;
  localparam logic [15:0] OFF_RX_LO  = 16'h2014;
  localparam logic [15:0] OFF_RX_HI  = 16'h2018;

  typedef struct packed {
    logic [63:0] data;
    logic        sop;
    logic        eop;
  } beat_t;

  // Status word layout: count in 15:8, start flag bit 1, end flag bit 0.
  function automatic logic [31:0] status_word(input logic [7:0] cnt,
                                              input logic sop, input logic eop);
    return {16'h0000, cnt, 6'b000000, sop, eop};
  endfunction

  function automatic beat_t make_beat(input logic [31:0] hi, input logic [31:0] lo,
                                      input logic [1:0] flags);
    beat_t b;
    b.data = {hi, lo};
    b.sop  = flags[1];
    b.eop  = flags[0];
    return b;
  endfunction
endpackage

// File: rtl/mbx_tx.sv
module mbx_tx
  import mbx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic        wr_ctrl,
  input  logic [31:0] wdata,
  input  logic        out_ready,
  output logic [31:0] lo_q,
  output logic [31:0] hi_q,
  output logic [1:0]  ctrl_q,
  output beat_t       out_beat,
  output logic        out_valid,
  output logic        ctrl_stall
);
  logic pend;
  logic accept;

  assign accept     = wr_ctrl & ~pend;
  assign ctrl_stall = wr_ctrl & pend;
  assign out_valid  = pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q     <= '0;
      hi_q     <= '0;
      ctrl_q   <= '0;
      out_beat <= '0;
      pend     <= 1'b0;
    end else begin
      if (wr_lo) lo_q <= wdata;
      if (wr_hi) hi_q <= wdata;
      if (accept) begin
        ctrl_q   <= wdata[1:0];
        out_beat <= make_beat(hi_q, lo_q, wdata[1:0]);
        pend     <= 1'b1;
      end else if (pend && out_ready) begin
        pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mbx_rx_fifo.sv
module mbx_rx_fifo
  import mbx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  beat_t            in_beat,
  input  logic             pop,
  output beat_t            head,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] count
);
  beat_t            mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_beat;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/mbx_status.sv
module mbx_status (
  input  logic clk,
  input  logic rst_n,
  input  logic head_valid,
  input  logic head_sop,
  input  logic head_eop,
  input  logic pop,
  input  logic clr,
  output logic head_new,
  output logic sop_flag,
  output logic eop_flag
);
  logic head_seen;

  // One pulse per beat that reaches the head of the queue.
  assign head_new = head_valid & ~head_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_seen <= 1'b0;
      sop_flag  <= 1'b0;
      eop_flag  <= 1'b0;
    end else begin
      if (pop)             head_seen <= 1'b0;
      else if (head_valid) head_seen <= 1'b1;
      sop_flag <= (sop_flag & ~clr) | (head_new & head_sop);
      eop_flag <= (eop_flag & ~clr) | (head_new & head_eop);
    end
  end
endmodule

// File: rtl/pkt_mailbox.sv
module pkt_mailbox
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mm_addr,
  input  logic              mm_read,
  input  logic              mm_write,
  input  logic [31:0]       mm_wdata,
  output logic [31:0]       mm_rdata,
  output logic              mm_waitreq,
  output logic [63:0]       tx_data,
  output logic              tx_sop,
  output logic              tx_eop,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [63:0]       rx_data,
  input  logic              rx_sop,
  input  logic              rx_eop,
  input  logic              rx_valid,
  output logic              rx_ready
);
  logic sel_lo, sel_hi, sel_ctrl, sel_status, sel_rlo, sel_rhi;
  assign sel_lo     = (mm_addr == ADDR_W'(OFF_TX_LO));
  assign sel_hi     = (mm_addr == ADDR_W'(OFF_TX_HI));
  assign sel_ctrl   = (mm_addr == ADDR_W'(OFF_CTRL));
  assign sel_status = (mm_addr == ADDR_W'(OFF_STATUS));
  assign sel_rlo    = (mm_addr == ADDR_W'(OFF_RX_LO));
  assign sel_rhi    = (mm_addr == ADDR_W'(OFF_RX_HI));

  // Named internal events, used by the bound checker.
  logic             push, pop, rd_status, head_new, sop_flag, eop_flag;
  logic             fifo_empty, fifo_full;
  logic [CNT_W-1:0] fifo_count;
  beat_t            head, rx_beat, tx_beat;
  logic [31:0]      lo_q, hi_q;
  logic [1:0]       ctrl_q;

  assign rx_ready  = ~fifo_full;
  assign push      = rx_valid & rx_ready;
  assign pop       = mm_read & sel_rhi & ~fifo_empty;
  assign rd_status = mm_read & sel_status;
  assign rx_beat   = '{data: rx_data, sop: rx_sop, eop: rx_eop};

  mbx_tx tx_i (
    .clk(clk), .rst_n(rst_n),
    .wr_lo(mm_write & sel_lo), .wr_hi(mm_write & sel_hi),
    .wr_ctrl(mm_write & sel_ctrl), .wdata(mm_wdata),
    .out_ready(tx_ready), .lo_q(lo_q), .hi_q(hi_q), .ctrl_q(ctrl_q),
    .out_beat(tx_beat), .out_valid(tx_valid), .ctrl_stall(mm_waitreq)
  );

  assign tx_data = tx_beat.data;
  assign tx_sop  = tx_beat.sop;
  assign tx_eop  = tx_beat.eop;

  mbx_rx_fifo #(.DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .push(push), .in_beat(rx_beat), .pop(pop),
    .head(head), .empty(fifo_empty), .full(fifo_full), .count(fifo_count)
  );

  mbx_status status_i (
    .clk(clk), .rst_n(rst_n), .head_valid(~fifo_empty),
    .head_sop(head.sop), .head_eop(head.eop), .pop(pop), .clr(rd_status),
    .head_new(head_new), .sop_flag(sop_flag), .eop_flag(eop_flag)
  );

  always_comb begin
    mm_rdata = '0;
    if (sel_lo)     mm_rdata = lo_q;
    if (sel_hi)     mm_rdata = hi_q;
    if (sel_ctrl)   mm_rdata = {30'd0, ctrl_q};
    if (sel_status) mm_rdata = status_word(8'(fifo_count), sop_flag, eop_flag);
    if (sel_rlo && !fifo_empty) mm_rdata = head.data[31:0];
    if (sel_rhi && !fifo_empty) mm_rdata = head.data[63:32];
  end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mm_addr,
  input logic              mm_read,
  input logic              mm_write,
  input logic [31:0]       mm_rdata,
  input logic              mm_waitreq,
  input logic [63:0]       tx_data,
  input logic              tx_sop,
  input logic              tx_eop,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_ready,
  input logic [CNT_W-1:0]  fifo_count,
  input logic              push,
  input logic              pop,
  input logic              rd_status,
  input logic              head_new,
  input logic              sop_flag,
  input logic              eop_flag
);
  logic mapped;
  assign mapped = (mm_addr == ADDR_W'(OFF_TX_LO)) || (mm_addr == ADDR_W'(OFF_TX_HI)) ||
                  (mm_addr == ADDR_W'(OFF_CTRL))  || (mm_addr == ADDR_W'(OFF_STATUS)) ||
                  (mm_addr == ADDR_W'(OFF_RX_LO)) || (mm_addr == ADDR_W'(OFF_RX_HI));

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!tx_valid && rx_ready && fifo_count == '0));

  assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop)));

  assert_stall_scope_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mm_waitreq |-> (mm_write && mm_addr == ADDR_W'(OFF_CTRL) && tx_valid));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CNT_W'(DEPTH));

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (fifo_count == CNT_W'($past(fifo_count) + 1'b1)));

  assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status |-> (mm_rdata[31:16] == 16'h0 && mm_rdata[7:2] == 6'h0));

  assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !head_new) |=> (!sop_flag && !eop_flag));

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_read && !mapped) |-> (mm_rdata == 32'h0));
endmodule

bind pkt_mailbox mbx_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) chk_i (.*);

// File: tb/pkt_mailbox_tb_top.sv
module pkt_mailbox_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] mm_addr = '0;
  logic        mm_read = 1'b0, mm_write = 1'b0;
  logic [31:0] mm_wdata = '0;
  logic [31:0] mm_rdata;
  logic        mm_waitreq;
  logic [63:0] tx_data;
  logic        tx_sop, tx_eop, tx_valid;
  logic        tx_ready = 1'b0;
  logic [63:0] rx_data = '0;
  logic        rx_sop = 1'b0, rx_eop = 1'b0, rx_valid = 1'b0;
  logic        rx_ready;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  pkt_mailbox dut_i (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic mm_wr(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk);
    mm_addr = a; mm_wdata = d; mm_write = 1'b1;
    #1;
    while (mm_waitreq) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 mm_write = 1'b0;
  endtask

  task automatic mm_rd(input logic [13:0] a, output logic [31:0] d);
    @(negedge clk);
    mm_addr = a; mm_read = 1'b1;
    #1 d = mm_rdata;
    @(posedge clk);
    #1 mm_read = 1'b0;
  endtask

  task automatic rx_push(input logic [63:0] d, input logic s, input logic e);
    @(negedge clk);
    rx_data = d; rx_sop = s; rx_eop = e; rx_valid = 1'b1;
    @(posedge clk);
    #1 rx_valid = 1'b0;
  endtask

  function automatic logic [31:0] exp_status(input int cnt, input bit s, input bit e);
    return cnt * 256 + (s ? 2 : 0) + (e ? 1 : 0);
  endfunction

  function automatic logic [63:0] rx_word(input int i);
    return {32'hC0DE_0000 + i * 32'h0000_0111, ~(32'h1357_0000 + i)};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    logic [31:0] lo, hi;
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 rx_ready", rx_ready, 1);
    mm_rd(14'h2000, r); chk("R1 lo reg", r, 0);
    mm_rd(14'h2004, r); chk("R1 hi reg", r, 0);
    mm_rd(14'h2008, r); chk("R1 ctrl reg", r, 0);
    mm_rd(14'h2010, r); chk("R1 status", r, 0);
    mm_rd(14'h2014, r); chk("R1 rx lo", r, 0);
    mm_rd(14'h2018, r); chk("R1 rx hi", r, 0);

    // R2 data registers
    mm_wr(14'h2000, 32'hDEAD_BEEF);
    mm_wr(14'h2004, 32'h0123_4567);
    mm_rd(14'h2000, r); chk("R2 lo readback", r, 32'hDEAD_BEEF);
    mm_rd(14'h2004, r); chk("R2 hi readback", r, 32'h0123_4567);

    // R3, R10: all four framing combinations
    for (int i = 0; i < 4; i++) begin
      lo = 32'h1000_0001 + i * 32'h0101_0101;
      hi = ~lo ^ (32'h0000_00FF << (i * 8));
      mm_wr(14'h2000, lo);
      mm_wr(14'h2004, hi);
      mm_wr(14'h2008, i);
      @(negedge clk);
      chk("R3 tx_valid after commit", tx_valid, 1);
      chk("R10 tx_data unchanged", tx_data, {hi, lo});
      chk("R3 tx_sop from bit 1", tx_sop, (i >> 1) & 1);
      chk("R3 tx_eop from bit 0", tx_eop, i & 1);
      mm_rd(14'h2008, r); chk("R3 ctrl readback", r, i);
      idle(2);
      chk("R3 held without ready", tx_data, {hi, lo});
      @(negedge clk) tx_ready = 1'b1;
      @(posedge clk); #1 tx_ready = 1'b0;
      chk("R3 taken on ready", tx_valid, 0);
    end

    // R4 stall while pending
    mm_wr(14'h2000, 32'hAAAA_0001);
    mm_wr(14'h2004, 32'hBBBB_0001);
    mm_wr(14'h2008, 32'h2);
    mm_wr(14'h2000, 32'hAAAA_0002);
    chk("R4 data write does not alter pending beat", tx_data, 64'hBBBB_0001_AAAA_0001);
    @(negedge clk);
    mm_addr = 14'h2008; mm_wdata = 32'h1; mm_write = 1'b1;
    #1 chk("R4 waitreq on commit while pending", mm_waitreq, 1);
    idle(3);
    chk("R4 still stalled", mm_waitreq, 1);
    chk("R4 first beat held", tx_data, 64'hBBBB_0001_AAAA_0001);
    @(negedge clk) tx_ready = 1'b1;
    @(posedge clk); #1 tx_ready = 1'b0;
    chk("R4 stall released", mm_waitreq, 0);
    @(posedge clk); #1 mm_write = 1'b0;
    chk("R4 second beat data", tx_data, 64'hBBBB_0001_AAAA_0002);
    chk("R4 second beat eop", {tx_sop, tx_eop}, 2'b01);
    @(negedge clk) tx_ready = 1'b1;
    @(posedge clk); #1 tx_ready = 1'b0;

    // R9 unmapped accesses
    mm_wr(14'h200C, 32'hFFFF_FFFF);
    mm_wr(14'h2FFC, 32'hFFFF_FFFF);
    mm_wr(14'h2010, 32'hFFFF_FFFF);
    mm_wr(14'h0000, 32'hFFFF_FFFF);
    chk("R9 no transmit from unmapped write", tx_valid, 0);
    mm_rd(14'h2000, r); chk("R9 lo unchanged", r, 32'hAAAA_0002);
    mm_rd(14'h2004, r); chk("R9 hi unchanged", r, 32'hBBBB_0001);
    mm_rd(14'h200C, r); chk("R9 unmapped read", r, 0);
    mm_rd(14'h2FFC, r); chk("R9 unmapped read high", r, 0);
    mm_rd(14'h2010, r); chk("R9 status unchanged", r, 0);

    // R6, R7, R8: three-beat packet
    rx_push(rx_word(0), 1, 0);
    rx_push(rx_word(1), 0, 0);
    rx_push(rx_word(2), 0, 1);
    idle(2);
    mm_rd(14'h2010, r); chk("R7 start flag and count", r, exp_status(3, 1, 0));
    mm_rd(14'h2010, r); chk("R7 cleared by read", r, exp_status(3, 0, 0));
    for (int i = 0; i < 3; i++) begin
      mm_rd(14'h2014, r); chk("R8 head low", r, rx_word(i) & 64'hFFFF_FFFF);
      mm_rd(14'h2018, r); chk("R8 head high", r, rx_word(i) >> 32);
      idle(2);
      mm_rd(14'h2010, r);
      chk("R6 R7 status after pop", r, exp_status(2 - i, 0, i == 1));
    end
    mm_rd(14'h2010, r); chk("R7 end flag cleared", r, 0);
    mm_rd(14'h2014, r); chk("R8 empty low", r, 0);
    mm_rd(14'h2018, r); chk("R8 empty high", r, 0);
    mm_rd(14'h2010, r); chk("R8 empty pop leaves count", r, 0);

    // R5 fill to 16, overflow attempt, ordered drain
    for (int i = 0; i < 16; i++) begin
      chk("R5 ready before full", rx_ready, 1);
      rx_push(rx_word(100 + i), i == 0, i == 15);
    end
    chk("R5 not ready when full", rx_ready, 0);
    rx_push(64'hFFFF_FFFF_FFFF_FFFF, 0, 0);
    idle(1);
    mm_rd(14'h2010, r); chk("R5 R6 count at full", r, exp_status(16, 1, 0));
    for (int i = 0; i < 16; i++) begin
      mm_rd(14'h2014, r); chk("R5 R10 drain low", r, rx_word(100 + i) & 64'hFFFF_FFFF);
      mm_rd(14'h2018, r); chk("R5 R10 drain high", r, rx_word(100 + i) >> 32);
    end
    chk("R5 ready after drain", rx_ready, 1);
    idle(2);
    mm_rd(14'h2010, r); chk("R5 count after drain", r[15:8], 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule